// File: doc/BRIEF.md
# Video Test Pattern Generator

This block drives test pictures into a 24-bit RGB video path. It makes four pictures: a checkerboard, a column-stripe picture for panel common-voltage checks, a full field of one programmable color, and a horizontal gray ramp. A set of static configuration inputs selects among them and adjusts their look. Square size can be 1x1 or 8x8 pixels. The lit squares can be white or the custom color. Output can be full 8-bit or reduced 6-bit channel depth, and all colors can be inverted.

The pixel timing comes from one of two sources. The first is the data-enable, horizontal-sync and vertical-sync inputs of an upstream source. The second is a built-in raster counter sized by parameters. The block passes the selected timing to its outputs with a one-clock delay, together with the pixel color. Pattern selection changes only at the start of a frame. When auto-scroll is on, the block steps through a masked subset of the pictures after a programmable number of frames.

Top module: `tpat_gen`

## Requirements
- R1: While reset is held, all outputs are 0. After reset the active pattern is code 0 (checkerboard) until the first frame start.
- R2: With `cfg_int_timing` = 0, `out_de`, `out_hs` and `out_vs` equal `ext_de`, `ext_hs` and `ext_vs` of the previous clock.
- R3: With `cfg_int_timing` = 1, the external timing inputs are ignored. The raster is H_TOTAL clocks per line and V_TOTAL lines per frame. Data enable covers the first H_ACTIVE clocks of the first V_ACTIVE lines. Hsync is high for the last HSYNC_W clocks of each line. Vsync is high for the last VSYNC_W whole lines of a frame.
- R4: Pixel column x counts data-enable clocks within a line, starting at 0. Row y counts lines with data enable since the last vsync rise, starting at 0. Pattern code 0 lights a pixel when (cx + cy) is even. Here cx = x and cy = y, or x/8 and y/8 when `cfg_scale8` = 1. Unlit pixels are black.
- R5: The lit color of patterns 0 and 1 is white (FFFFFF) when `cfg_custom` = 0 and `cfg_color` when it is 1. RGB packing is R in bits 23:16, G in 15:8 and B in 7:0.
- R6: Pattern code 1 lights a pixel when cx is even, which gives vertical stripes 1 or 8 pixels wide.
- R7: Pattern code 2 outputs `cfg_color` on every active pixel.
- R8: Pattern code 3 drives the same level on all three channels. The level is min(x / S, L-1), where L is 256 (8-bit) or 64 (6-bit) and S = max(1, H_ACTIVE / L). In 6-bit mode the level sits in the top six bits of each channel.
- R9: With `cfg_depth18` = 1, the two low bits of every channel are 0 for every pattern.
- R10: With `cfg_invert` = 1, the active channel bits are inverted (all 8 bits, or the top 6 bits in 6-bit mode).
- R11: When the output data enable is low, `out_rgb` is 0 whatever the invert setting.
- R12: A new pattern takes effect only at a vsync rising edge. With auto-scroll off, the value of `cfg_pat_sel` at that edge is loaded. A change in the middle of a frame has no effect until the next frame.
- R13: With `cfg_autoscroll` = 1, every vsync rise counts a frame. After F frames (F = `cfg_frames`, where 0 counts as 1), the pattern moves to the next code whose bit is set in `cfg_pat_en` (bit i enables code i). The search skips cleared bits and wraps from 3 to 0.
- R14: With auto-scroll on and `cfg_pat_en` = 0, the pattern never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_scale8 | input | 1 | 8x8 squares and stripes |
| cfg_custom | input | 1 | Lit squares use the custom color |
| cfg_depth18 | input | 1 | 6 bits per channel |
| cfg_int_timing | input | 1 | Use the internal raster |
| cfg_invert | input | 1 | Invert active color bits |
| cfg_autoscroll | input | 1 | Step through enabled patterns |
| cfg_pat_sel | input | 2 | Pattern code when auto-scroll is off |
| cfg_pat_en | input | 4 | Auto-scroll enable mask, bit i for code i |
| cfg_frames | input | FRAME_W | Frames per pattern in auto-scroll |
| cfg_color | input | 24 | Custom color |
| ext_de | input | 1 | External data enable |
| ext_hs | input | 1 | External horizontal sync |
| ext_vs | input | 1 | External vertical sync |
| out_de | output | 1 | Data enable out |
| out_hs | output | 1 | Horizontal sync out |
| out_vs | output | 1 | Vertical sync out |
| out_rgb | output | 24 | Pixel color |

## Verification
The sweep uses an active width of 130. With that width, the 6-bit ramp steps every two pixels and then clamps at 63, so an unclamped or unstepped ramp would print wrong levels on the right part of each line. The 10-line frames make the 8x8 checker change row parity at line 8, which catches a design that scales only horizontally. Another run moves the pattern select in mid-frame and looks for a frame split across two pictures. The auto-scroll runs cover a mask with a hole, a zero frame count and an empty mask, which catch a design that lands on a disabled pattern, never wraps, divides by zero or walks through patterns with no enables. In internal-timing mode the external inputs toggle every clock, so a design that leaks them shows wrong line lengths, sync widths or frame periods.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

   localparam int NUM_PAT = 4;
   localparam int PAT_W   = 2;
   localparam int CH_W    = 8;
   localparam int RGB_W   = 3 * CH_W;

   typedef enum logic [PAT_W-1:0] {
      PAT_CHECK = 2'd0,
      PAT_COLS  = 2'd1,
      PAT_SOLID = 2'd2,
      PAT_RAMP  = 2'd3
   } pat_e;

endpackage

// File: rtl/tpg_raster.sv
module tpg_raster #(
   parameter int H_TOTAL  = 136,
   parameter int H_ACTIVE = 130,
   parameter int HSYNC_W  = 2,
   parameter int V_TOTAL  = 12,
   parameter int V_ACTIVE = 10,
   parameter int VSYNC_W  = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic de,
   output logic hs,
   output logic vs
);

   localparam int HW = $clog2(H_TOTAL);
   localparam int VW = $clog2(V_TOTAL);

   logic [HW-1:0] h_cnt;
   logic [VW-1:0] v_cnt;
   logic          line_end;

   assign line_end = (h_cnt == HW'(H_TOTAL - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_cnt <= '0;
         v_cnt <= '0;
      end else if (line_end) begin
         h_cnt <= '0;
         v_cnt <= (v_cnt == VW'(V_TOTAL - 1)) ? '0 : v_cnt + 1'b1;
      end else begin
         h_cnt <= h_cnt + 1'b1;
      end
   end

   assign de = (h_cnt < HW'(H_ACTIVE)) && (v_cnt < VW'(V_ACTIVE));
   assign hs = (h_cnt >= HW'(H_TOTAL - HSYNC_W));
   assign vs = (v_cnt >= VW'(V_TOTAL - VSYNC_W));

   // R3: counters stay inside the configured raster
   a_r3_h_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, h_cnt} < (HW+1)'(H_TOTAL));
   a_r3_v_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, v_cnt} < (VW+1)'(V_TOTAL));
   // R3: a frame start always falls on the first clock of a line
   a_r3_vs_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vs) |-> (h_cnt == '0));

endmodule

// File: rtl/tpg_coord.sv
module tpg_coord #(
   parameter int XW = 9,
   parameter int YW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          de,
   input  logic          vs,
   output logic [XW-1:0] col,
   output logic          row_bit0,
   output logic          row_bit3,
   output logic          frame_start
);

   logic [YW-1:0] row_q;
   logic          de_q;
   logic          vs_q;

   assign frame_start = vs & ~vs_q;
   assign row_bit0    = row_q[0];
   assign row_bit3    = row_q[3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col   <= '0;
         row_q <= '0;
         de_q  <= 1'b0;
         vs_q  <= 1'b0;
      end else begin
         de_q <= de;
         vs_q <= vs;
         if (!de)
            col <= '0;
         else if (col != '1)
            col <= col + 1'b1;
         if (frame_start)
            row_q <= '0;
         else if (de_q && !de && row_q != '1)
            row_q <= row_q + 1'b1;
      end
   end

   // R4: the first active pixel of every run sits at column 0
   a_r4_col_restart: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(de_q) |-> (col == XW'(1)));

endmodule

// File: rtl/tpg_scroll.sv
module tpg_scroll
   import tpg_pkg::*;
#(
   parameter int FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_start,
   input  logic               auto_en,
   input  logic [PAT_W-1:0]   sel,
   input  logic [NUM_PAT-1:0] en,
   input  logic [FRAME_W-1:0] frames,
   output logic [PAT_W-1:0]   pat
);

   logic [FRAME_W-1:0] fcnt;
   logic [FRAME_W:0]   limit;
   logic [FRAME_W:0]   fcnt_inc;
   logic               due;
   logic [PAT_W-1:0]   next_pat;

   assign limit    = (frames == '0) ? (FRAME_W+1)'(1) : {1'b0, frames};
   assign fcnt_inc = {1'b0, fcnt} + (FRAME_W+1)'(1);
   assign due      = (fcnt_inc >= limit);

   // nearest enabled code after the current one, wrapping; unchanged if none
   always_comb begin
      logic found;
      logic [PAT_W-1:0] cand;
      found    = 1'b0;
      next_pat = pat;
      for (int k = 1; k <= NUM_PAT; k++) begin
         cand = pat + PAT_W'(k);
         if (!found && en[cand]) begin
            next_pat = cand;
            found    = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pat  <= PAT_CHECK;
         fcnt <= '0;
      end else if (frame_start) begin
         if (!auto_en) begin
            pat  <= sel;
            fcnt <= '0;
         end else if (due) begin
            pat  <= next_pat;
            fcnt <= '0;
         end else begin
            fcnt <= fcnt_inc[FRAME_W-1:0];
         end
      end
   end

   // R12: the pattern is frozen between frame starts
   a_r12_hold_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(pat));
   // R12: with auto-scroll off the select input is taken at the frame start
   a_r12_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !auto_en) |=> (pat == $past(sel)));
   // R13: an advance always lands on an enabled code
   a_r13_lands_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && auto_en && due && en != '0) |=> ((($past(en) >> pat) & 4'd1) != 4'd0));
   // R14: an empty mask freezes the pattern
   a_r14_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && en == '0) |=> $stable(pat));

endmodule

// File: rtl/tpg_pixel.sv
module tpg_pixel
   import tpg_pkg::*;
#(
   parameter int H_ACTIVE = 130,
   parameter int XW       = 9
) (
   input  logic [XW-1:0]    col,
   input  logic             row_bit0,
   input  logic             row_bit3,
   input  logic [PAT_W-1:0] pat,
   input  logic             scale8,
   input  logic             custom,
   input  logic             depth18,
   input  logic             invert,
   input  logic [RGB_W-1:0] color,
   output logic [RGB_W-1:0] rgb
);

   localparam int unsigned STEP_FULL = (H_ACTIVE / 256 < 1) ? 1 : H_ACTIVE / 256;
   localparam int unsigned STEP_SIX  = (H_ACTIVE / 64 < 1) ? 1 : H_ACTIVE / 64;

   logic             cpar;
   logic             rpar;
   logic [31:0]      q_full;
   logic [31:0]      q_six;
   logic [CH_W-1:0]  gray;
   logic [RGB_W-1:0] lit;
   logic [RGB_W-1:0] base;
   logic [CH_W-1:0]  ch_mask;

   assign cpar    = scale8 ? col[3] : col[0];
   assign rpar    = scale8 ? row_bit3 : row_bit0;
   assign lit     = custom ? color : '1;
   assign ch_mask = depth18 ? 8'hFC : 8'hFF;

   always_comb begin
      q_full = 32'(col) / STEP_FULL;
      q_six  = 32'(col) / STEP_SIX;
      if (depth18)
         gray = (q_six > 32'd63) ? 8'hFC : {q_six[5:0], 2'b00};
      else
         gray = (q_full > 32'd255) ? 8'hFF : q_full[7:0];
   end

   always_comb begin
      case (pat)
         PAT_CHECK: base = (cpar ^ rpar) ? '0 : lit;
         PAT_COLS:  base = cpar ? '0 : lit;
         PAT_SOLID: base = color;
         default:   base = {gray, gray, gray};
      endcase
   end

   for (genvar ch = 0; ch < 3; ch++) begin : g_chan
      assign rgb[ch*CH_W +: CH_W] =
         (invert ? ~base[ch*CH_W +: CH_W] : base[ch*CH_W +: CH_W]) & ch_mask;
   end

endmodule

// File: rtl/tpat_gen.sv
module tpat_gen
   import tpg_pkg::*;
#(
   parameter int H_TOTAL        = 136,
   parameter int H_ACTIVE       = 130,
   parameter int HSYNC_W        = 2,
   parameter int V_TOTAL        = 12,
   parameter int V_ACTIVE       = 10,
   parameter int VSYNC_W        = 2,
   parameter int FRAME_W        = 8,
   parameter bit HAS_INT_TIMING = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_scale8,
   input  logic               cfg_custom,
   input  logic               cfg_depth18,
   input  logic               cfg_int_timing,
   input  logic               cfg_invert,
   input  logic               cfg_autoscroll,
   input  logic [1:0]         cfg_pat_sel,
   input  logic [3:0]         cfg_pat_en,
   input  logic [FRAME_W-1:0] cfg_frames,
   input  logic [23:0]        cfg_color,
   input  logic               ext_de,
   input  logic               ext_hs,
   input  logic               ext_vs,
   output logic               out_de,
   output logic               out_hs,
   output logic               out_vs,
   output logic [23:0]        out_rgb
);

   localparam int XW = $clog2(H_TOTAL) + 1;
   localparam int YW = $clog2(V_TOTAL) + 1;

   if (H_TOTAL < 8 || V_TOTAL < 8)
      $error("tpat_gen: raster must be at least 8x8");
   if (H_ACTIVE < 1 || H_ACTIVE >= H_TOTAL || V_ACTIVE < 1 || V_ACTIVE >= V_TOTAL)
      $error("tpat_gen: active area must fit inside the total raster");
   if (HSYNC_W < 1 || HSYNC_W > H_TOTAL - H_ACTIVE)
      $error("tpat_gen: hsync must fit in horizontal blanking");
   if (VSYNC_W < 1 || VSYNC_W > V_TOTAL - V_ACTIVE)
      $error("tpat_gen: vsync must fit in vertical blanking");
   if (FRAME_W < 1)
      $error("tpat_gen: frame counter needs at least one bit");

   logic int_de, int_hs, int_vs, use_int;
   logic src_de, src_hs, src_vs;

   if (HAS_INT_TIMING) begin : g_int
      tpg_raster #(
         .H_TOTAL (H_TOTAL),  .H_ACTIVE(H_ACTIVE), .HSYNC_W(HSYNC_W),
         .V_TOTAL (V_TOTAL),  .V_ACTIVE(V_ACTIVE), .VSYNC_W(VSYNC_W)
      ) u_raster (
         .clk(clk), .rst_n(rst_n), .de(int_de), .hs(int_hs), .vs(int_vs)
      );
      assign use_int = cfg_int_timing;
   end else begin : g_no_int
      assign int_de  = 1'b0;
      assign int_hs  = 1'b0;
      assign int_vs  = 1'b0;
      assign use_int = 1'b0;
   end

   assign src_de = use_int ? int_de : ext_de;
   assign src_hs = use_int ? int_hs : ext_hs;
   assign src_vs = use_int ? int_vs : ext_vs;

   logic [XW-1:0]    col;
   logic             row_bit0, row_bit3, frame_start;
   logic [PAT_W-1:0] pat;
   logic [RGB_W-1:0] pix;

   tpg_coord #(.XW(XW), .YW(YW)) u_coord (
      .clk(clk), .rst_n(rst_n), .de(src_de), .vs(src_vs),
      .col(col), .row_bit0(row_bit0), .row_bit3(row_bit3),
      .frame_start(frame_start)
   );

   tpg_scroll #(.FRAME_W(FRAME_W)) u_scroll (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .auto_en(cfg_autoscroll), .sel(cfg_pat_sel), .en(cfg_pat_en),
      .frames(cfg_frames), .pat(pat)
   );

   tpg_pixel #(.H_ACTIVE(H_ACTIVE), .XW(XW)) u_pixel (
      .col(col), .row_bit0(row_bit0), .row_bit3(row_bit3), .pat(pat),
      .scale8(cfg_scale8), .custom(cfg_custom), .depth18(cfg_depth18),
      .invert(cfg_invert), .color(cfg_color), .rgb(pix)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_de  <= 1'b0;
         out_hs  <= 1'b0;
         out_vs  <= 1'b0;
         out_rgb <= '0;
      end else begin
         out_de  <= src_de;
         out_hs  <= src_hs;
         out_vs  <= src_vs;
         out_rgb <= src_de ? pix : '0;
      end
   end

   // R2: external timing passes through with one clock of delay
   a_r2_follow_ext: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_int_timing |=> (out_de == $past(ext_de) && out_hs == $past(ext_hs)
                           && out_vs == $past(ext_vs)));
   // R9: reduced depth never drives the two low bits of a channel
   a_r9_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_depth18 |=> ((out_rgb & 24'h030303) == '0));
   // R11: blanking is black
   a_r11_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
      !out_de |-> (out_rgb == '0));

endmodule

// File: tb/tpat_gen_tb.sv
module tpat_gen_tb;

   localparam int CLK_PERIOD = 10;
   localparam int HT = 136, HA = 130, HSW = 2;
   localparam int VT = 12,  VA = 10,  VSW = 2;
   localparam int FW = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_scale8 = 0, cfg_custom = 0, cfg_depth18 = 0, cfg_int_timing = 0;
   logic cfg_invert = 0, cfg_autoscroll = 0;
   logic [1:0]    cfg_pat_sel = 0;
   logic [3:0]    cfg_pat_en = 0;
   logic [FW-1:0] cfg_frames = 0;
   logic [23:0]   cfg_color = 24'h3CA517;
   logic ext_de = 0, ext_hs = 0, ext_vs = 0;
   logic out_de, out_hs, out_vs;
   logic [23:0] out_rgb;

   tpat_gen #(.H_TOTAL(HT), .H_ACTIVE(HA), .HSYNC_W(HSW), .V_TOTAL(VT),
              .V_ACTIVE(VA), .VSYNC_W(VSW), .FRAME_W(FW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_scale8(cfg_scale8), .cfg_custom(cfg_custom),
      .cfg_depth18(cfg_depth18), .cfg_int_timing(cfg_int_timing),
      .cfg_invert(cfg_invert), .cfg_autoscroll(cfg_autoscroll),
      .cfg_pat_sel(cfg_pat_sel), .cfg_pat_en(cfg_pat_en), .cfg_frames(cfg_frames),
      .cfg_color(cfg_color), .ext_de(ext_de), .ext_hs(ext_hs), .ext_vs(ext_vs),
      .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs), .out_rgb(out_rgb)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, fails = 0;
   bit done = 0;
   int exp_pat = 0, fcnt = 0;
   string tag_extra = "";

   logic p_valid = 0, p_de, p_hs, p_vs;
   logic [23:0] p_rgb;
   string p_tag;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // expected color from the requirement formulas (R4..R10)
   function automatic logic [23:0] model(input int pat, input int x, input int y);
      int cx, cy, lv, st, lvl, g;
      logic [23:0] fg, b;
      cx = cfg_scale8 ? x / 8 : x;
      cy = cfg_scale8 ? y / 8 : y;
      fg = cfg_custom ? cfg_color : 24'hFFFFFF;
      case (pat)
         0: b = ((cx + cy) % 2 == 0) ? fg : 24'h0;
         1: b = (cx % 2 == 0) ? fg : 24'h0;
         2: b = cfg_color;
         default: begin
            lv  = cfg_depth18 ? 64 : 256;
            st  = HA / lv;
            if (st < 1) st = 1;
            lvl = x / st;
            if (lvl > lv - 1) lvl = lv - 1;
            g = cfg_depth18 ? lvl * 4 : lvl;
            b = {8'(g), 8'(g), 8'(g)};
         end
      endcase
      if (cfg_invert) b = ~b;
      if (cfg_depth18) b = b & 24'hFCFCFC;
      return b;
   endfunction

   function automatic string mtag();
      string s;
      case (exp_pat)
         0: s = cfg_custom ? "R4 R5" : "R4";
         1: s = cfg_custom ? "R6 R5" : "R6";
         2: s = "R7";
         default: s = "R8";
      endcase
      if (cfg_depth18) s = {s, " R9"};
      if (cfg_invert) s = {s, " R10"};
      return {s, tag_extra};
   endfunction

   // pattern bookkeeping at each frame start (R12, R13, R14)
   task automatic frame_begin();
      int lim;
      if (!cfg_autoscroll) begin
         exp_pat = cfg_pat_sel;
         fcnt = 0;
      end else begin
         lim = (cfg_frames == 0) ? 1 : int'(cfg_frames);
         fcnt++;
         if (fcnt >= lim) begin
            fcnt = 0;
            for (int k = 1; k <= 4; k++) begin
               if (cfg_pat_en[(exp_pat + k) % 4]) begin
                  exp_pat = (exp_pat + k) % 4;
                  break;
               end
            end
         end
      end
   endtask

   task automatic step(input logic de, input logic hs, input logic vs,
                       input logic [23:0] rgb, input string tag);
      @(negedge clk);
      if (p_valid) begin
         chk(out_de === p_de, "R2", "de", 32'(out_de), 32'(p_de));
         chk(out_hs === p_hs, "R2", "hs", 32'(out_hs), 32'(p_hs));
         chk(out_vs === p_vs, "R2", "vs", 32'(out_vs), 32'(p_vs));
         chk(out_rgb === p_rgb, p_tag, "rgb", 32'(out_rgb), 32'(p_rgb));
      end
      ext_de = de; ext_hs = hs; ext_vs = vs;
      p_de = de; p_hs = hs; p_vs = vs; p_rgb = rgb; p_tag = tag; p_valid = 1;
   endtask

   task automatic ext_frame(input int midsel);
      for (int i = 0; i < 20; i++) begin
         step(0, 0, 1, 24'h0, "R11");
         if (i == 0) frame_begin();
      end
      for (int y = 0; y < VA; y++) begin
         if (y == 5 && midsel >= 0) cfg_pat_sel = 2'(midsel);
         for (int x = 0; x < HA; x++) step(1, 0, 0, model(exp_pat, x, y), mtag());
         for (int b = 0; b < 6; b++) step(0, (b >= 2 && b < 4), 0, 24'h0, "R11");
      end
   endtask

   task automatic int_run(input int cycles);
      int nrise = 0, period = 0, vs_len = 0, hs_len = 0, x = 0, y = 0, lines = 0;
      logic pvs = 0, phs = 0, pde = 0;
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         ext_de = ~ext_de; ext_vs = ~ext_vs; ext_hs = 1'b1;
         period++;
         if (out_vs && !pvs) begin
            if (nrise >= 1) begin
               chk(period == HT * VT, "R3", "frame period", period, HT * VT);
               chk(lines == VA, "R3", "active lines", lines, VA);
            end
            nrise++; period = 0; vs_len = 0; lines = 0; y = 0;
            frame_begin();
         end
         if (!out_vs && pvs && nrise >= 1)
            chk(vs_len == VSW * HT, "R3", "vsync width", vs_len, VSW * HT);
         if (!out_hs && phs && nrise >= 1)
            chk(hs_len == HSW, "R3", "hsync width", hs_len, HSW);
         if (out_vs) vs_len++;
         if (out_hs) hs_len++; else hs_len = 0;
         if (out_de) begin
            if (nrise >= 1)
               chk(out_rgb === model(exp_pat, x, y), {mtag(), " R3"}, "int rgb",
                   32'(out_rgb), 32'(model(exp_pat, x, y)));
            x++;
         end else begin
            if (pde) begin
               if (nrise >= 1) chk(x == HA, "R3", "line width", x, HA);
               lines++; y++;
            end
            x = 0;
            if (nrise >= 1)
               chk(out_rgb === 24'h0, "R11", "int blank rgb", 32'(out_rgb), 0);
         end
         pvs = out_vs; phs = out_hs; pde = out_de;
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(out_de === 0 && out_hs === 0 && out_vs === 0, "R1", "sync in reset",
          {29'd0, out_de, out_hs, out_vs}, 0);
      chk(out_rgb === 24'h0, "R1", "rgb in reset", 32'(out_rgb), 0);
      @(negedge clk); rst_n = 1;

      // reset pattern (code 0) held by an empty mask
      cfg_autoscroll = 1; cfg_pat_en = 4'b0000; cfg_frames = 1; cfg_pat_sel = 2;
      tag_extra = " R1 R14";
      repeat (3) ext_frame(-1);

      // mid-frame select change
      cfg_autoscroll = 0; cfg_pat_sel = 1; tag_extra = " R12";
      ext_frame(-1);
      ext_frame(2);
      ext_frame(-1);

      // auto-scroll with a hole in the mask, then frame count 0
      cfg_custom = 1; cfg_autoscroll = 1; cfg_pat_en = 4'b1011; cfg_frames = 2;
      tag_extra = " R13";
      repeat (9) ext_frame(-1);
      cfg_pat_en = 4'b0110; cfg_frames = 0;
      repeat (4) ext_frame(-1);

      // sweep of every pattern and option combination
      cfg_autoscroll = 0; tag_extra = "";
      for (int p = 0; p < 4; p++) begin
         for (int o = 0; o < 16; o++) begin
            cfg_pat_sel = 2'(p);
            {cfg_scale8, cfg_custom, cfg_depth18, cfg_invert} = 4'(o);
            ext_frame(-1);
         end
      end
      step(0, 0, 0, 24'h0, "R11");
      @(negedge clk);
      chk(out_rgb === 24'h0, "R11", "final blank", 32'(out_rgb), 0);
      p_valid = 0;

      // internal raster, 6-bit ramp (step 2 then clamp), external inputs toggling
      cfg_int_timing = 1; cfg_pat_sel = 3; cfg_depth18 = 1; cfg_invert = 0;
      cfg_scale8 = 0; cfg_custom = 0; tag_extra = "";
      int_run(5 * HT * VT);
      // internal raster, scaled checker with inversion
      cfg_pat_sel = 0; cfg_scale8 = 1; cfg_invert = 1; cfg_depth18 = 0;
      int_run(3 * HT * VT);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule